// File: doc/BRIEF.md
# Video Line Prefetch Scheduler

This block keeps a display fed from a frame held in external byte-wide memory. The frame is 640 by 480 pixels at two bytes per pixel, so one display line is 1280 bytes. The block fetches each line as two back-to-back 640-byte bursts from a memory master, and it fetches them one line ahead of the display. At the 25 MHz pixel clock that gives the memory a whole line period to deliver the next line.

The block watches the sync outputs of a separate VGA timing generator. A frame is armed only after vertical sync has been high and has then returned low. It then preloads line 0 right away. Each later rising edge of horizontal sync hands the finished line to the display side and starts the fetch of the next one. Bytes from a burst with an even index land in the lower half of the line being filled. Bytes from a burst with an odd index land in the upper half. Two line stores alternate, so the display always reads a complete line.

The display side gives a pixel index and gets back a 16-bit RGB565 word one cycle later. The word is assembled little-endian from the byte pair. If a line is still being fetched when the next horizontal sync arrives, a sticky underrun flag is raised.

Top module: `line_prefetch_sched`

## Requirements
- R1: After synchronous reset the block requests nothing, the underrun flag is 0 and the pixel output is 0.
- R2: No burst is requested until vertical sync has been seen high and then low. Horizontal sync edges before that start nothing.
- R3: Once armed, the block requests the two bursts of line 0 before any horizontal sync. A request stays asserted with a stable address until it is accepted. The next request comes only after all H_PIXELS bytes of the current burst have been received.
- R4: On each rising edge of horizontal sync that finds the previous line complete, exactly two bursts are requested for the next line. Between such edges no request is made.
- R5: Burst k is requested at external byte address k*H_PIXELS, and k counts up by one for each burst.
- R6: When the burst count reaches 2*V_LINES, it returns to 0 and no request is made until vertical sync is again seen high and then low. The first request after that uses address 0.
- R7: Bytes of an even-numbered burst fill line bytes 0..H_PIXELS-1. Bytes of an odd-numbered burst fill line bytes H_PIXELS..2*H_PIXELS-1.
- R8: A horizontal sync edge that finds a line complete makes that line the displayed one. The displayed line is not changed while the next line is being fetched.
- R9: The pixel word for index p is {line byte 2p+1, line byte 2p}, registered one cycle after the index is presented.
- R10: A horizontal sync edge while a line's bursts are still pending sets the underrun flag. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync_i | input | 1 | Vertical sync from the timing source, active high |
| hsync_i | input | 1 | Horizontal sync from the timing source, event on rising edge |
| mreq_valid_o | output | 1 | Burst request to the memory master |
| mreq_addr_o | output | ADDR_W | Byte address of the requested burst |
| mreq_ready_i | input | 1 | Memory master accepts the request |
| mrd_valid_i | input | 1 | A returned byte is valid, only after acceptance |
| mrd_byte_i | input | 8 | Returned byte, in ascending address order |
| pix_idx_i | input | PIX_W | Pixel index within the displayed line, below H_PIXELS |
| pix_word_o | output | 16 | RGB565 pixel word, one cycle after the index |
| underrun_o | output | 1 | Sticky line-late flag |

## Verification
The bench first holds vertical sync high without letting it fall, and sends a horizontal sync before arming. A scheduler that triggered on a single vsync level or on hsync would fetch too early. It then reads every pixel of each displayed line, with the lower-half and upper-half pixels coming from different bursts. Swapped half steering or a swapped byte order inside the word shows up as wrong pixel values. It also reads the old line while the next one is being fetched, which exposes a bank that flips too early. Around the end of the frame it checks the last burst address and that extra horizontal syncs fetch nothing, so a wrong wrap count shows up as an extra or missing burst. Finally it stalls the memory across two horizontal syncs. A correct design keeps the underrun flag at 0 at the first of these syncs, because the line it was waiting for is already complete. It raises the flag at the second sync, while the new line's burst is still unanswered, and the flag stays set after the memory resumes.

// File: rtl/lps_pkg.sv
package lps_pkg;

  // Scheduler phases: two arming steps, fetch in progress, line ready
  typedef enum logic [1:0] {
    ST_ARM_HI = 2'd0,
    ST_ARM_LO = 2'd1,
    ST_LOAD   = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_t;

endpackage

// File: rtl/lps_sync_mon.sv
module lps_sync_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vsync_i,
  input  logic hsync_i,
  output logic vs_lvl,
  output logic hs_rise
);

  logic [SYNC_STAGES-1:0] vs_sh;
  logic [SYNC_STAGES:0]   hs_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_sh <= '0;
      hs_sh <= '0;
    end else begin
      vs_sh <= {vs_sh[SYNC_STAGES-2:0], vsync_i};
      hs_sh <= {hs_sh[SYNC_STAGES-1:0], hsync_i};
    end
  end

  assign vs_lvl  = vs_sh[SYNC_STAGES-1];
  assign hs_rise = hs_sh[SYNC_STAGES-1] & ~hs_sh[SYNC_STAGES];

endmodule

// File: rtl/lps_burst_seq.sv
module lps_burst_seq
  import lps_pkg::*;
#(
  parameter int H_PIXELS = 640,
  parameter int V_LINES  = 480,
  parameter int ADDR_W   = 20,
  parameter int CNT_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vs_lvl,
  input  logic              hs_rise,
  output logic              mreq_valid_o,
  output logic [ADDR_W-1:0] mreq_addr_o,
  input  logic              mreq_ready_i,
  input  logic              mrd_valid_i,
  output logic              wr_en,
  output logic              wr_bank,
  output logic              wr_half,
  output logic [CNT_W-1:0]  wr_cnt,
  output logic              disp_bank,
  output logic              underrun_o
);

  localparam int BURSTS   = 2 * V_LINES;
  localparam int IDX_W    = $clog2(BURSTS + 1);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(BURSTS - 1);
  localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(H_PIXELS - 1);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(H_PIXELS);

  seq_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  cnt;
  logic              in_burst;
  logic              ready;
  logic              fill_bank;
  logic              beat;
  logic              burst_end;

  assign beat      = in_burst & mrd_valid_i;
  assign burst_end = beat & (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_ARM_HI;
      idx          <= '0;
      cnt          <= '0;
      in_burst     <= 1'b0;
      ready        <= 1'b0;
      fill_bank    <= 1'b0;
      disp_bank    <= 1'b1;
      underrun_o   <= 1'b0;
      mreq_valid_o <= 1'b0;
      mreq_addr_o  <= '0;
    end else begin
      unique case (state)
        ST_ARM_HI: begin
          if (vs_lvl) state <= ST_ARM_LO;
        end
        ST_ARM_LO: begin
          if (!vs_lvl) begin
            state        <= ST_LOAD;
            idx          <= '0;
            mreq_addr_o  <= '0;
            mreq_valid_o <= 1'b1;
            ready        <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (mreq_valid_o && mreq_ready_i) begin
            mreq_valid_o <= 1'b0;
            in_burst     <= 1'b1;
          end
          if (beat) cnt <= burst_end ? '0 : cnt + 1'b1;
          if (burst_end) begin
            in_burst <= 1'b0;
            if (!idx[0]) begin
              idx          <= idx + 1'b1;
              mreq_addr_o  <= mreq_addr_o + STEP;
              mreq_valid_o <= 1'b1;
            end else if (idx == LAST_IDX) begin
              idx         <= '0;
              mreq_addr_o <= '0;
              ready       <= 1'b1;
              state       <= ST_ARM_HI;
            end else begin
              idx         <= idx + 1'b1;
              mreq_addr_o <= mreq_addr_o + STEP;
              ready       <= 1'b1;
              state       <= ST_HOLD;
            end
          end
          if (hs_rise) underrun_o <= 1'b1;
        end
        ST_HOLD: begin
          if (hs_rise) begin
            mreq_valid_o <= 1'b1;
            state        <= ST_LOAD;
          end
        end
        default: state <= ST_ARM_HI;
      endcase

      // a completed line is handed to the display on the sync edge
      if (hs_rise && ready && state != ST_LOAD) begin
        disp_bank <= fill_bank;
        fill_bank <= ~fill_bank;
        ready     <= 1'b0;
      end
    end
  end

  assign wr_en   = beat;
  assign wr_bank = fill_bank;
  assign wr_half = idx[0];
  assign wr_cnt  = cnt;

endmodule

// File: rtl/lps_line_store.sv
module lps_line_store #(
  parameter int H_PIXELS = 640,
  parameter int CNT_W    = 10,
  parameter int PIX_W    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_bank,
  input  logic             wr_half,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [7:0]       wr_byte,
  input  logic             rd_bank,
  input  logic [PIX_W-1:0] rd_idx,
  output logic [15:0]      rd_word
);

  // each lane holds one byte of every pixel of both line banks
  localparam int DEPTH = 2 * H_PIXELS;
  localparam int MA_W  = $clog2(DEPTH);

  logic [MA_W-1:0] waddr;
  logic [MA_W-1:0] raddr;

  assign waddr = (wr_bank ? MA_W'(H_PIXELS) : '0)
               + (wr_half ? MA_W'(H_PIXELS / 2) : '0)
               + MA_W'(wr_cnt >> 1);
  assign raddr = (rd_bank ? MA_W'(H_PIXELS) : '0) + MA_W'(rd_idx);

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;
    logic       sel;

    assign sel = (wr_cnt[0] == (lane == 1));

    always_ff @(posedge clk) begin
      if (wr_en && sel) mem[waddr] <= wr_byte;
    end

    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= mem[raddr];
    end
  end

  assign rd_word = {g_lane[1].q, g_lane[0].q};

endmodule

// File: rtl/line_prefetch_sched.sv
module line_prefetch_sched #(
  parameter int H_PIXELS    = 640,
  parameter int V_LINES     = 480,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(2 * H_PIXELS * V_LINES),
  localparam int PIX_W      = $clog2(H_PIXELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vsync_i,
  input  logic              hsync_i,
  output logic              mreq_valid_o,
  output logic [ADDR_W-1:0] mreq_addr_o,
  input  logic              mreq_ready_i,
  input  logic              mrd_valid_i,
  input  logic [7:0]        mrd_byte_i,
  input  logic [PIX_W-1:0]  pix_idx_i,
  output logic [15:0]       pix_word_o,
  output logic              underrun_o
);

  localparam int CNT_W = $clog2(H_PIXELS);

  logic             vs_lvl;
  logic             hs_rise;
  logic             wr_en;
  logic             wr_bank;
  logic             wr_half;
  logic [CNT_W-1:0] wr_cnt;
  logic             disp_bank;

  lps_sync_mon #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .vsync_i (vsync_i),
    .hsync_i (hsync_i),
    .vs_lvl  (vs_lvl),
    .hs_rise (hs_rise)
  );

  lps_burst_seq #(
    .H_PIXELS (H_PIXELS),
    .V_LINES  (V_LINES),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .vs_lvl       (vs_lvl),
    .hs_rise      (hs_rise),
    .mreq_valid_o (mreq_valid_o),
    .mreq_addr_o  (mreq_addr_o),
    .mreq_ready_i (mreq_ready_i),
    .mrd_valid_i  (mrd_valid_i),
    .wr_en        (wr_en),
    .wr_bank      (wr_bank),
    .wr_half      (wr_half),
    .wr_cnt       (wr_cnt),
    .disp_bank    (disp_bank),
    .underrun_o   (underrun_o)
  );

  lps_line_store #(
    .H_PIXELS (H_PIXELS),
    .CNT_W    (CNT_W),
    .PIX_W    (PIX_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_bank (wr_bank),
    .wr_half (wr_half),
    .wr_cnt  (wr_cnt),
    .wr_byte (mrd_byte_i),
    .rd_bank (disp_bank),
    .rd_idx  (pix_idx_i),
    .rd_word (pix_word_o)
  );

endmodule

// File: rtl/lps_chk.sv
module lps_chk #(
  parameter int H_PIXELS = 640,
  parameter int V_LINES  = 480,
  localparam int ADDR_W  = $clog2(2 * H_PIXELS * V_LINES),
  localparam int PIX_W   = $clog2(H_PIXELS)
) (
  input logic              clk,
  input logic              rst,
  input logic              mreq_valid_o,
  input logic [ADDR_W-1:0] mreq_addr_o,
  input logic              mreq_ready_i,
  input logic              underrun_o,
  input logic [15:0]       pix_word_o
);

  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(H_PIXELS);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'((2 * V_LINES - 1) * H_PIXELS);

  logic              accept;
  logic              seen;
  logic [ADDR_W-1:0] last_addr;

  assign accept = mreq_valid_o & mreq_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen      <= 1'b0;
      last_addr <= '0;
    end else if (accept) begin
      seen      <= 1'b1;
      last_addr <= mreq_addr_o;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mreq_valid_o && !underrun_o && pix_word_o == 16'h0));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mreq_valid_o && !mreq_ready_i) |=> (mreq_valid_o && $stable(mreq_addr_o)));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && seen) |-> (mreq_addr_o == last_addr + STEP || mreq_addr_o == '0));

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    mreq_valid_o |-> (mreq_addr_o <= TOP_ADDR));

  // R10
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underrun_o |=> underrun_o);

endmodule

bind line_prefetch_sched lps_chk #(.H_PIXELS(H_PIXELS), .V_LINES(V_LINES)) u_chk (.*);

// File: tb/sim_line_prefetch_sched.sv
module sim_line_prefetch_sched;

  localparam int H  = 8;
  localparam int V  = 4;
  localparam int AW = $clog2(2 * H * V);
  localparam int PW = $clog2(H);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vsync_i = 1'b0;
  logic          hsync_i = 1'b0;
  logic          mreq_valid_o;
  logic [AW-1:0] mreq_addr_o;
  logic          mreq_ready_i = 1'b0;
  logic          mrd_valid_i = 1'b0;
  logic [7:0]    mrd_byte_i = 8'h0;
  logic [PW-1:0] pix_idx_i = '0;
  logic [15:0]   pix_word_o;
  logic          underrun_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit resp_en = 1'b1;
  int acc_n = 0;
  int acc_addr [0:31];
  int overlap = 0;

  always #5 clk = ~clk;

  line_prefetch_sched #(.H_PIXELS(H), .V_LINES(V)) u0 (.*);

  function automatic logic [7:0] ext_byte(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // memory master model: accepts a request, then streams H bytes
  initial begin
    forever begin
      @(negedge clk);
      if (mreq_valid_o && resp_en && !rst) begin
        int base;
        base = int'(mreq_addr_o);
        if (acc_n < 32) acc_addr[acc_n] = base;
        acc_n++;
        mreq_ready_i = 1'b1;
        @(negedge clk);
        mreq_ready_i = 1'b0;
        for (int k = 0; k < H; k++) begin
          if (mreq_valid_o) overlap++;
          mrd_valid_i = 1'b1;
          mrd_byte_i  = ext_byte(base + k);
          @(negedge clk);
        end
        mrd_valid_i = 1'b0;
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_hs();
    @(negedge clk);
    hsync_i = 1'b1;
    idle(2);
    hsync_i = 1'b0;
  endtask

  task automatic check_line(int line, string tag);
    for (int p = 0; p < H; p++) begin
      int exp;
      @(negedge clk);
      pix_idx_i = PW'(p);
      @(negedge clk);
      exp = {ext_byte(line * 2 * H + 2 * p + 1), ext_byte(line * 2 * H + 2 * p)};
      chk(pix_word_o == 16'(exp), tag, $sformatf("line %0d pixel %0d", line, p),
          int'(pix_word_o), exp);
    end
  endtask

  task automatic t_reset();
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk(!mreq_valid_o, "R1", "request after reset", int'(mreq_valid_o), 0);
    chk(!underrun_o, "R1", "underrun after reset", int'(underrun_o), 0);
    chk(pix_word_o == 16'h0, "R1", "pixel after reset", int'(pix_word_o), 0);
  endtask

  task automatic t_arm();
    pulse_hs();
    idle(10);
    chk(acc_n == 0, "R2", "bursts after early hsync", acc_n, 0);
    vsync_i = 1'b1;
    idle(20);
    chk(acc_n == 0, "R2", "bursts with vsync only high", acc_n, 0);
    vsync_i = 1'b0;
    idle(40);
    chk(acc_n == 2, "R3", "preload bursts", acc_n, 2);
    chk(acc_addr[0] == 0, "R5", "first burst address", acc_addr[0], 0);
    chk(acc_addr[1] == H, "R5", "second burst address", acc_addr[1], H);
  endtask

  task automatic t_lines();
    pulse_hs();
    idle(40);
    chk(acc_n == 4, "R4", "bursts after hsync 1", acc_n, 4);
    chk(acc_addr[2] == 2 * H && acc_addr[3] == 3 * H, "R5", "line 1 addresses",
        acc_addr[3], 3 * H);
    // line 1 is complete in the other bank; display still on line 0
    check_line(0, "R7_R8_R9");
    idle(20);
    chk(acc_n == 4, "R4", "no bursts between hsyncs", acc_n, 4);
    pulse_hs();
    idle(40);
    check_line(1, "R8");
  endtask

  task automatic t_wrap();
    pulse_hs();
    idle(40);
    pulse_hs();
    idle(40);
    chk(acc_n == 8, "R6", "bursts in full frame", acc_n, 8);
    chk(acc_addr[7] == 7 * H, "R5", "last burst address", acc_addr[7], 7 * H);
    check_line(3, "R8");
    pulse_hs();
    idle(40);
    chk(acc_n == 8, "R6", "no bursts after frame end", acc_n, 8);
    check_line(3, "R8");
    chk(!underrun_o, "R10", "no underrun in clean frame", int'(underrun_o), 0);
    chk(overlap == 0, "R3", "request during burst data", overlap, 0);
    vsync_i = 1'b1;
    idle(10);
    vsync_i = 1'b0;
    idle(40);
    chk(acc_n == 10, "R6", "bursts after re-arm", acc_n, 10);
    chk(acc_addr[8] == 0, "R6", "address after wrap", acc_addr[8], 0);
  endtask

  task automatic t_underrun();
    resp_en = 1'b0;
    pulse_hs();
    idle(10);
    chk(!underrun_o, "R10", "underrun with line ready", int'(underrun_o), 0);
    pulse_hs();
    idle(10);
    chk(underrun_o, "R10", "underrun on late line", int'(underrun_o), 1);
    resp_en = 1'b1;
    idle(40);
    chk(acc_n == 12, "R10", "late line still fetched", acc_n, 12);
    pulse_hs();
    idle(10);
    chk(underrun_o, "R10", "underrun stays set", int'(underrun_o), 1);
  endtask

  initial begin
    t_reset();
    t_arm();
    t_lines();
    t_wrap();
    t_underrun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule